// File: doc/BRIEF.md
# Viterbi Survivor-Bit Packing Store Unit

This block is the store stage for one step of a Viterbi add-compare-select loop. Each request carries four source registers, four per-lane decision flags, a variant code and an endian-mode bit. From these the block builds 16-bit survivor words. Each word is a half of one of two candidate registers, shifted left by one bit, with a new survivor bit placed in the LSB. The words go out as a single 64-bit write to a simple single-cycle memory port. A quad store occupies all eight byte lanes and a pair store occupies one 32-bit half, marked by byte enables.

A quad store also passes two plain halves through ahead of the two survivor words. The low-half variants work on bits 15:0 of every source and the high-half variants on bits 31:16. Endian mode sets the word order within each pair and the byte order within each word. The unit takes the current address and an offset, and returns the post-incremented address. A misaligned request is rejected: the block raises an error and writes nothing.

Top module: `vit_surv_store`

## Requirements
- R1: While `rst` is high and on the cycle after, `req_ready`=1 and `mem_we`, `align_err` and `addr_out_vld` are 0.
- R2: `variant` encoding: bit 1 = 0 selects a quad store and 1 a pair store. Bit 0 = 0 selects source bits 15:0 and 1 selects bits 31:16. A quad store passes through halves W0 from `src_pass0` and W1 from `src_pass1`.
- R3: Survivor word W2 is `{alt_half[14:0],1'b0}` when its flag is set, else `{keep_half[14:0],1'b0}`. W2's flag is `flags[0]` for the low halves and `flags[1]` for the high halves.
- R4: Survivor word W3 is `{alt_half[14:0],1'b0}` when its flag is set, else `{keep_half[14:0],1'b1}`. W3's flag is `flags[2]` for the low halves and `flags[3]` for the high halves.
- R5: High-half stores ignore `flags[0]` and `flags[2]`. Low-half stores ignore `flags[1]` and `flags[3]`.
- R6: With `big_endian`=0, the words go to ascending addresses in the order W0, W1, W2, W3. Each word's low byte sits at the lower address. Byte lane k of `mem_wdata` is bits 8k+7:8k, at address `mem_addr`+k.
- R7: With `big_endian`=1, the order within each pair is swapped (W1, W0, W3, W2), and each word's high byte sits at the lower address.
- R8: A quad store drives `mem_be`=8'hFF. A pair store drives 8'h0F when address bit 2 is 0, else 8'hF0, with the unused lanes zero. `mem_addr` is the address with bits 2:0 cleared.
- R9: A quad store needs address bits 2:0 = 0 and a pair store needs bits 1:0 = 0. A misaligned request pulses `align_err` for one cycle and writes nothing. Its `addr_out` equals the unchanged address.
- R10: An aligned request presents `addr_out` = `addr_in` + `offset_in`, with `addr_out_vld`, on the cycle after acceptance.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. `mem_we` pulses for exactly the next cycle, and `req_ready` is low during that cycle. A request seen while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request |
| req_ready | output | 1 | Unit can accept a request |
| variant | input | 2 | Bit 1: pair store; bit 0: high halves |
| big_endian | input | 1 | Endian mode |
| flags | input | 4 | Per-lane decision flags |
| src_pass0 | input | REG_W | First pass-through register |
| src_pass1 | input | REG_W | Second pass-through register |
| src_keep | input | REG_W | Candidate register for the flag-clear path |
| src_alt | input | REG_W | Candidate register for the flag-set path |
| addr_in | input | ADDR_W | Current address register value |
| offset_in | input | ADDR_W | Post-increment offset |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Doubleword-aligned write address |
| mem_wdata | output | 4*WORD_W | Write data, byte lane k at bits 8k+7:8k |
| mem_be | output | 4*WORD_W/8 | Byte enables |
| addr_out | output | ADDR_W | Updated address register value |
| addr_out_vld | output | 1 | `addr_out` valid |
| align_err | output | 1 | Misaligned request rejected |

## Verification
The bound assertions watch the handshake on every cycle. They check that the write strobe and the error are one-cycle pulses, that ready is low while a write is out, and that the post-incremented or unchanged address appears one cycle after acceptance. They also check that every write uses one of the three legal byte-enable shapes. Only the bench's scenarios can show the packed data itself. Those scenarios cover the shift and fill bits of each survivor word, which flags steer each half, and the word and byte order in each endian mode and pair position.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef enum logic [1:0] {
    VS_QUAD_LO = 2'b00,
    VS_QUAD_HI = 2'b01,
    VS_PAIR_LO = 2'b10,
    VS_PAIR_HI = 2'b11
  } vss_variant_e;

  function automatic logic vss_is_pair(input vss_variant_e v);
    return v[1];
  endfunction

  function automatic logic vss_is_high(input vss_variant_e v);
    return v[0];
  endfunction
endpackage

// File: rtl/vss_half_pick.sv
module vss_half_pick #(
  parameter int REG_W  = 32,
  parameter int WORD_W = 16,
  parameter int NREG   = 4
) (
  input  logic [NREG-1:0][REG_W-1:0]  regs,
  input  logic                        use_high,
  output logic [NREG-1:0][WORD_W-1:0] halves
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign halves[i] = use_high ? regs[i][REG_W-1 -: WORD_W] : regs[i][WORD_W-1:0];
  end
endmodule

// File: rtl/vss_survivor_word.sv
module vss_survivor_word #(
  parameter int   WORD_W = 16,
  parameter logic FILL   = 1'b0
) (
  input  logic [WORD_W-1:0] keep_half,
  input  logic [WORD_W-1:0] alt_half,
  input  logic              pick_alt,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    if (pick_alt) word = {alt_half[WORD_W-2:0], 1'b0};
    else          word = {keep_half[WORD_W-2:0], FILL};
  end
endmodule

// File: rtl/vss_lane_map.sv
module vss_lane_map #(
  parameter int WORD_W = 16,
  localparam int SLOTS = 4,
  localparam int BPW   = WORD_W / 8,
  localparam int NBYTE = SLOTS * BPW
) (
  input  logic [SLOTS-1:0][WORD_W-1:0] words,
  input  logic                         pair_mode,
  input  logic                         upper_half,
  input  logic                         big_endian,
  output logic [NBYTE*8-1:0]           data,
  output logic [NBYTE-1:0]             be
);
  logic [SLOTS-1:0][WORD_W-1:0] slot;
  logic [SLOTS-1:0]             slot_en;
  logic [WORD_W-1:0]            first_s, second_s;

  always_comb begin
    first_s  = big_endian ? words[3] : words[2];
    second_s = big_endian ? words[2] : words[3];
    slot     = '0;
    slot_en  = '0;
    if (!pair_mode) begin
      slot[0] = big_endian ? words[1] : words[0];
      slot[1] = big_endian ? words[0] : words[1];
      slot[2] = first_s;
      slot[3] = second_s;
      slot_en = 4'b1111;
    end else if (upper_half) begin
      slot[2] = first_s;
      slot[3] = second_s;
      slot_en = 4'b1100;
    end else begin
      slot[0] = first_s;
      slot[1] = second_s;
      slot_en = 4'b0011;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      assign data[(s*BPW+b)*8 +: 8] = big_endian ? slot[s][(BPW-1-b)*8 +: 8]
                                                 : slot[s][b*8 +: 8];
      assign be[s*BPW+b] = slot_en[s];
    end
  end
endmodule

// File: rtl/vit_surv_store.sv
module vit_surv_store
  import vss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int WORD_W = 16,
  localparam int DATA_W = 4 * WORD_W,
  localparam int BE_W   = DATA_W / 8,
  localparam int QA_B   = $clog2(BE_W),
  localparam int PA_B   = $clog2(BE_W / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        variant,
  input  logic              big_endian,
  input  logic [3:0]        flags,
  input  logic [REG_W-1:0]  src_pass0,
  input  logic [REG_W-1:0]  src_pass1,
  input  logic [REG_W-1:0]  src_keep,
  input  logic [REG_W-1:0]  src_alt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] offset_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_out_vld,
  output logic              align_err
);
  vss_variant_e             var_e;
  logic                     pair_m, high_m, aligned, accept;
  logic [3:0][REG_W-1:0]    regs;
  logic [3:0][WORD_W-1:0]   halves;
  logic [3:0][WORD_W-1:0]   words;
  logic [1:0]               pick;
  logic [DATA_W-1:0]        pack_data;
  logic [BE_W-1:0]          pack_be;

  assign var_e  = vss_variant_e'(variant);
  assign pair_m = vss_is_pair(var_e);
  assign high_m = vss_is_high(var_e);
  assign regs   = {src_alt, src_keep, src_pass1, src_pass0};

  vss_half_pick #(.REG_W(REG_W), .WORD_W(WORD_W), .NREG(4)) u_pick (
    .regs    (regs),
    .use_high(high_m),
    .halves  (halves)
  );

  // lane 0 steered by flags[0]/[1], lane 1 by flags[2]/[3]
  assign pick[0] = high_m ? flags[1] : flags[0];
  assign pick[1] = high_m ? flags[3] : flags[2];
  assign words[0] = halves[0];
  assign words[1] = halves[1];

  for (genvar l = 0; l < 2; l++) begin : g_surv
    vss_survivor_word #(.WORD_W(WORD_W), .FILL(l == 1)) u_word (
      .keep_half(halves[2]),
      .alt_half (halves[3]),
      .pick_alt (pick[l]),
      .word     (words[2+l])
    );
  end

  vss_lane_map #(.WORD_W(WORD_W)) u_map (
    .words     (words),
    .pair_mode (pair_m),
    .upper_half(addr_in[PA_B]),
    .big_endian(big_endian),
    .data      (pack_data),
    .be        (pack_be)
  );

  assign aligned = pair_m ? (addr_in[PA_B-1:0] == '0) : (addr_in[QA_B-1:0] == '0);
  assign accept  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready    <= 1'b1;
      mem_we       <= 1'b0;
      align_err    <= 1'b0;
      addr_out_vld <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_be       <= '0;
      addr_out     <= '0;
    end else begin
      req_ready    <= !accept;
      mem_we       <= accept && aligned;
      align_err    <= accept && !aligned;
      addr_out_vld <= accept;
      if (accept) addr_out <= aligned ? addr_in + offset_in : addr_in;
      if (accept && aligned) begin
        mem_addr  <= {addr_in[ADDR_W-1:QA_B], {QA_B{1'b0}}};
        mem_wdata <= pack_data;
        mem_be    <= pack_be;
      end
    end
  end
endmodule

// File: rtl/vit_surv_store_chk.sv
module vit_surv_store_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  localparam int BE_W = 4 * WORD_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        variant,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] offset_in,
  input logic              mem_we,
  input logic [BE_W-1:0]   mem_be,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_out_vld,
  input logic              align_err
);
  localparam logic [BE_W-1:0] BE_ALL = '1;
  localparam logic [BE_W-1:0] BE_LO  = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  localparam logic [BE_W-1:0] BE_HI  = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

  logic ok;
  assign ok = variant[1] ? (addr_in[1:0] == 2'b00) : (addr_in[2:0] == 3'b000);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_we && !align_err && !addr_out_vld));

  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !req_ready);

  assert_post_incr_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ok) |=>
      (mem_we && addr_out_vld && addr_out == $past(addr_in) + $past(offset_in)));

  assert_misalign_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !ok) |=>
      (align_err && !mem_we && addr_out == $past(addr_in)));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    align_err |=> !align_err);

  assert_be_shape_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be == BE_ALL || mem_be == BE_LO || mem_be == BE_HI));
endmodule

bind vit_surv_store vit_surv_store_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .variant     (variant),
  .addr_in     (addr_in),
  .offset_in   (offset_in),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .addr_out    (addr_out),
  .addr_out_vld(addr_out_vld),
  .align_err   (align_err)
);

// File: tb/vit_surv_store_tb.sv
module vit_surv_store_tb;
  localparam int AW = 32;
  localparam int RW = 32;
  localparam int WW = 16;
  localparam int NV = 10;
  localparam int VW = 119;

  // {variant, big_endian, flags, addr16, off8, exp_be, exp_maddr16, exp_wdata}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b00, 1'b0, 4'h0, 16'h0100, 8'h08, 8'hFF, 16'h0100, 64'h8007_8006_5678_1234}, // R2 R3 R4 R6
    {2'b00, 1'b0, 4'h5, 16'h0108, 8'h10, 8'hFF, 16'h0108, 64'h1E1E_1E1E_5678_1234}, // R3 R4 alt path
    {2'b00, 1'b0, 4'h1, 16'h0110, 8'h08, 8'hFF, 16'h0110, 64'h8007_1E1E_5678_1234}, // R3 R4 mixed
    {2'b01, 1'b0, 4'h0, 16'h0118, 8'h08, 8'hFF, 16'h0118, 64'h0003_0002_B1B2_A1A2}, // R5 high
    {2'b01, 1'b0, 4'hA, 16'h0120, 8'h08, 8'hFF, 16'h0120, 64'h8004_8004_B1B2_A1A2}, // R5 high flags
    {2'b01, 1'b0, 4'h5, 16'h0128, 8'h08, 8'hFF, 16'h0128, 64'h0003_0002_B1B2_A1A2}, // R5 low flags ignored
    {2'b00, 1'b1, 4'h0, 16'h0130, 8'h08, 8'hFF, 16'h0130, 64'h0680_0780_3412_7856}, // R7 low
    {2'b01, 1'b1, 4'h0, 16'h0138, 8'h08, 8'hFF, 16'h0138, 64'h0200_0300_A2A1_B2B1}, // R7 high
    {2'b10, 1'b0, 4'h0, 16'h0204, 8'h04, 8'hF0, 16'h0200, 64'h8007_8006_0000_0000}, // R8 upper
    {2'b11, 1'b1, 4'h8, 16'h0200, 8'h04, 8'h0F, 16'h0200, 64'h0000_0000_0200_0480}  // R8 lower
  };

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0, big_endian = 1'b0;
  logic [1:0] variant = '0;
  logic [3:0] flags = '0;
  logic [RW-1:0] src_pass0 = 32'hA1A2_1234, src_pass1 = 32'hB1B2_5678;
  logic [RW-1:0] src_keep  = 32'h8001_C003, src_alt   = 32'h4002_0F0F;
  logic [AW-1:0] addr_in = '0, offset_in = '0;
  logic req_ready, mem_we, addr_out_vld, align_err;
  logic [AW-1:0] mem_addr, addr_out;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vit_surv_store #(.ADDR_W(AW), .REG_W(RW), .WORD_W(WW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .variant(variant), .big_endian(big_endian), .flags(flags),
    .src_pass0(src_pass0), .src_pass1(src_pass1), .src_keep(src_keep), .src_alt(src_alt),
    .addr_in(addr_in), .offset_in(offset_in), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .addr_out(addr_out),
    .addr_out_vld(addr_out_vld), .align_err(align_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_we && !align_err && !addr_out_vld, "R1 in reset",
        {60'd0, req_ready, mem_we, align_err, addr_out_vld}, 64'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_we && !align_err && !addr_out_vld, "R1 after reset",
        {60'd0, req_ready, mem_we, align_err, addr_out_vld}, 64'h8);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      variant    = v[118:117];
      big_endian = v[116];
      flags      = v[115:112];
      addr_in    = {16'd0, v[111:96]};
      offset_in  = {24'd0, v[95:88]};
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_we && !req_ready, "R11 write pulse", {62'd0, mem_we, req_ready}, 64'h2);
      chk(mem_wdata == v[63:0], "R2-R8 data", mem_wdata, v[63:0]); // R2 R3 R4 R5 R6 R7
      chk(mem_be == v[87:80], "R8 byte enables", {56'd0, mem_be}, {56'd0, v[87:80]});
      chk(mem_addr == {16'd0, v[79:64]}, "R8 address", {32'd0, mem_addr}, {48'd0, v[79:64]});
      chk(addr_out_vld && addr_out == {16'd0, v[111:96]} + {24'd0, v[95:88]}, "R10 post increment",
          {32'd0, addr_out}, {48'd0, v[111:96]} + {56'd0, v[95:88]});
      @(negedge clk);
      chk(!mem_we && req_ready, "R11 idle after write", {62'd0, mem_we, req_ready}, 64'h1);
    end

    // R9 misaligned quad store
    variant = 2'b00; addr_in = 32'h0000_0104; offset_in = 32'h8; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(align_err && !mem_we, "R9 quad misaligned", {62'd0, align_err, mem_we}, 64'h2);
    chk(addr_out == 32'h104, "R9 address kept", {32'd0, addr_out}, 64'h104);
    @(negedge clk);
    chk(!align_err, "R9 error single cycle", {63'd0, align_err}, 64'h0);

    // R9 misaligned pair store
    variant = 2'b10; addr_in = 32'h0000_0202; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(align_err && !mem_we && addr_out == 32'h202, "R9 pair misaligned",
        {32'd0, addr_out}, 64'h202);
    @(negedge clk);

    // R11 request held through busy cycle is ignored
    variant = 2'b00; addr_in = 32'h0000_0300; offset_in = 32'h8; req_valid = 1'b1;
    @(negedge clk);
    chk(mem_we && addr_out == 32'h308, "R11 accepted", {32'd0, addr_out}, 64'h308);
    addr_in = 32'h0000_0400;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_we && !addr_out_vld && addr_out == 32'h308, "R11 busy request ignored",
        {32'd0, addr_out}, 64'h308);

    // R1 reset mid-run
    req_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b0;
    chk(req_ready && !mem_we && !addr_out_vld, "R1 reset blocks request",
        {62'd0, req_ready, mem_we}, 64'h2);

    finish_run();
  end
endmodule